// File: doc/BRIEF.md
# Speaker Gate Control Port

An 8-bit system control register that sits next to a programmable interval timer. A write sets two control levels. One is the gate input of timer channel 2. The other is an enable for the speaker data path. A read returns a status byte. That byte holds the two control levels, the current level of the channel 2 timer output, and a refresh toggle that the block generates itself and that flips at a fixed rate.

The write is captured on the clock edge where the write strobe is high, and the new levels appear on the outputs one cycle later. The read byte is combinational, so it always shows the current register contents, the current refresh level and the live timer output. The refresh toggle comes from a free-running counter. Its half period is a parameter in system clock cycles: 2048 cycles at 125 MHz is about 16 µs.

Top module: `spkgate_port`

## Requirements
- R1: While reset is low at a clock edge, the gate level, the speaker enable and the refresh toggle are all 0 after that edge.
- R2: A write copies write-data bit 0 to `gate2_o`, and the new value is visible in the cycle after the write edge.
- R3: A write copies write-data bit 1 to `spk_en_o`, and the new value is visible in the cycle after the write edge.
- R4: In a cycle with no write strobe, `gate2_o` and `spk_en_o` keep their values.
- R5: Read bit 0 equals the gate level and read bit 1 equals the speaker enable.
- R6: Read bit 5 follows the `t2_out_i` input in the same cycle, with no register in the path.
- R7: Read bit 4 is the refresh toggle. It is 0 after reset and inverts after every REFRESH_HALF clock cycles. The first inversion happens exactly REFRESH_HALF cycles after reset is released.
- R8: Read bits 2, 3, 6 and 7 are always 0. Write-data bits 2 to 7 have no effect on any output.
- R9: Writes do not disturb the timing of the refresh toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 8 | Write data (bit 0 gate, bit 1 speaker enable) |
| t2_out_i | input | 1 | Output level of timer channel 2 |
| gate2_o | output | 1 | Gate level to timer channel 2 |
| spk_en_o | output | 1 | Speaker data enable |
| rd_data_o | output | 8 | Status byte |

## Verification
The assertions assume that reset is held low for at least one clock edge before it is released. They also assume that `wr_en_i`, `wr_data_i` and `t2_out_i` are stable around each rising edge. The refresh check keeps a counter of its own that restarts with reset, so it is only valid while the design's REFRESH_HALF matches the checker's. The bench drives every input on the falling edge and holds reset for several cycles. During the refresh scenario it keeps issuing writes, so the counter alignment is tested under traffic.

// File: rtl/spkgate_pkg.sv
// Package: bit positions and width of the speaker gate control byte.
// Assumes an 8-bit data path. Neighbouring logic decodes the positions below.
package spkgate_pkg;
    localparam int DATA_W      = 8;
    localparam int POS_GATE    = 0;
    localparam int POS_SPK     = 1;
    localparam int POS_REFRESH = 4;
    localparam int POS_T2OUT   = 5;

    typedef struct packed {
        logic spk_en;
        logic gate;
    } ctrl_t;
endpackage

// File: rtl/spkgate_ctrl_reg.sv
// Module: control register holding the gate level and the speaker enable.
// Assumes a one-cycle write strobe. The new value shows on the outputs in the next cycle.
module spkgate_ctrl_reg
    import spkgate_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output ctrl_t        ctrl
);
    ctrl_t ctrl_q;

    // Capture the two control bits on a write. Reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q.gate   <= wr_data[POS_GATE];
            ctrl_q.spk_en <= wr_data[POS_SPK];
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/spkgate_refresh.sv
// Module: free-running refresh toggle that inverts every HALF clock cycles.
// Assumes HALF >= 2. The counter restarts only on reset and ignores all other inputs.
module spkgate_refresh #(
    parameter int HALF = 2048
) (
    input  logic clk,
    input  logic rst_n,
    output logic toggle
);
    localparam int CNT_W = (HALF > 2) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             tog_q;
    logic             wrap;

    // Detect the last cycle of a half period.
    always_comb wrap = (cnt_q == LAST);

    // Advance the counter and invert the toggle when it wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            tog_q <= ~tog_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign toggle = tog_q;
endmodule

// File: rtl/spkgate_status_mux.sv
// Module: builds the status byte from the control bits, the refresh toggle and the timer output.
// Assumes that bit positions unused in the package read as zero. The module is purely combinational.
module spkgate_status_mux
    import spkgate_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  ctrl_t        ctrl,
    input  logic         refresh,
    input  logic         t2_out,
    output logic [W-1:0] status
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b == POS_GATE) begin : g_gate
            assign status[b] = ctrl.gate;
        end else if (b == POS_SPK) begin : g_spk
            assign status[b] = ctrl.spk_en;
        end else if (b == POS_REFRESH) begin : g_ref
            assign status[b] = refresh;
        end else if (b == POS_T2OUT) begin : g_t2
            assign status[b] = t2_out;
        end else begin : g_zero
            assign status[b] = 1'b0;
        end
    end
endmodule

// File: rtl/spkgate_port.sv
// Module: top of the speaker gate control port.
// Assumes a synchronous active-low reset and that t2_out_i comes from the channel 2 timer on the same clock.
module spkgate_port
    import spkgate_pkg::*;
#(
    parameter int REFRESH_HALF = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              t2_out_i,
    output logic              gate2_o,
    output logic              spk_en_o,
    output logic [DATA_W-1:0] rd_data_o
);
    ctrl_t ctrl;
    logic  refresh;

    spkgate_ctrl_reg #(.W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_data (wr_data_i),
        .ctrl    (ctrl)
    );

    spkgate_refresh #(.HALF(REFRESH_HALF)) u_refresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .toggle (refresh)
    );

    spkgate_status_mux #(.W(DATA_W)) u_mux (
        .ctrl    (ctrl),
        .refresh (refresh),
        .t2_out  (t2_out_i),
        .status  (rd_data_o)
    );

    assign gate2_o  = ctrl.gate;
    assign spk_en_o = ctrl.spk_en;
endmodule

// File: rtl/spkgate_port_chk.sv
// Module: property checker for spkgate_port, attached through bind.
// Assumes reset is held low for at least one edge and that HALF matches the design's REFRESH_HALF.
module spkgate_port_chk #(
    parameter int HALF = 2048
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic       t2_out_i,
    input logic       gate2_o,
    input logic       spk_en_o,
    input logic [7:0] rd_data_o
);
    localparam int CW = $clog2(HALF) + 1;
    logic [CW-1:0] win_q;

    // Independent cycle window for the refresh period.
    always_ff @(posedge clk) begin
        if (!rst_n)                 win_q <= '0;
        else if (win_q == CW'(HALF - 1)) win_q <= '0;
        else                        win_q <= win_q + 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!gate2_o && !spk_en_o && !rd_data_o[4])); // R1
    AST_WRITE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> gate2_o == $past(wr_data_i[0])); // R2
    AST_WRITE_SPK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> spk_en_o == $past(wr_data_i[1])); // R3
    AST_HOLD_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(gate2_o) && $stable(spk_en_o))); // R4
    AST_READ_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[1:0] == {spk_en_o, gate2_o}); // R5
    AST_READ_T2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[5] == t2_out_i); // R6
    AST_REFRESH_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[4] != $past(rd_data_o[4])) == ($past(win_q) == CW'(HALF - 1))); // R7
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[7:6] == 2'b00) && (rd_data_o[3:2] == 2'b00)); // R8
endmodule

bind spkgate_port spkgate_port_chk #(.HALF(REFRESH_HALF)) u_chk (.*);

// File: tb/spkgate_port_tb.sv
module spkgate_port_tb;
    localparam int HALF  = 100;
    localparam int LIMIT = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       t2_out_i = 1'b0;
    logic       gate2_o, spk_en_o;
    logic [7:0] rd_data_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    spkgate_port #(.REFRESH_HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .t2_out_i(t2_out_i), .gate2_o(gate2_o), .spk_en_o(spk_en_o), .rd_data_o(rd_data_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; wr_en_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_en_i = 1'b1; wr_data_i = d;
        @(negedge clk); wr_en_i = 1'b0; wr_data_i = 8'h00;
    endtask

    // R1: reset state of all outputs
    task automatic t_reset();
        do_reset();
        check("R1 gate", {7'd0, gate2_o}, 8'h00);
        check("R1 spk", {7'd0, spk_en_o}, 8'h00);
        check("R1 rd", rd_data_o, 8'h00);
        do_write(8'h03);
        do_reset();
        check("R1 after set", rd_data_o, 8'h00);
    endtask

    // R2 R3 R5: write patterns
    task automatic t_writes();
        for (int p = 0; p < 4; p++) begin
            do_write(8'(p));
            check("R2 gate", {7'd0, gate2_o}, 8'(p & 1));
            check("R3 spk", {7'd0, spk_en_o}, 8'((p >> 1) & 1));
            check("R5 rd low", {6'd0, rd_data_o[1:0]}, 8'(p));
        end
    endtask

    // R4: no strobe means hold, even with data on the bus
    task automatic t_hold();
        do_write(8'h02);
        @(negedge clk); wr_data_i = 8'h01;
        repeat (3) @(negedge clk);
        check("R4 hold gate", {7'd0, gate2_o}, 8'h00);
        check("R4 hold spk", {7'd0, spk_en_o}, 8'h01);
        wr_data_i = 8'h00;
    endtask

    // R6: timer output passes through in the same cycle
    task automatic t_t2();
        @(negedge clk); t2_out_i = 1'b1; #1;
        check("R6 t2 high", {7'd0, rd_data_o[5]}, 8'h01);
        @(negedge clk); t2_out_i = 1'b0; #1;
        check("R6 t2 low", {7'd0, rd_data_o[5]}, 8'h00);
    endtask

    // R8: upper write bits ignored and unused read bits zero
    task automatic t_unused();
        do_write(8'h00);
        do_write(8'hFC);
        check("R8 ignored gate/spk", {6'd0, spk_en_o, gate2_o}, 8'h00);
        @(negedge clk); t2_out_i = 1'b1; #1;
        check("R8 zero bits", rd_data_o & 8'hCC, 8'h00);
        t2_out_i = 1'b0;
    endtask

    // R7 R9: refresh timing with writes in flight
    task automatic t_refresh();
        do_reset();
        for (int i = 0; i < HALF - 1; i++) begin
            @(negedge clk);
            wr_en_i = (i % 7 == 0); wr_data_i = 8'(i);
        end
        wr_en_i = 1'b0;
        check("R7 before first flip", {7'd0, rd_data_o[4]}, 8'h00);
        @(negedge clk);
        check("R7 first flip", {7'd0, rd_data_o[4]}, 8'h01);
        for (int i = 0; i < HALF - 1; i++) begin
            @(negedge clk);
            wr_en_i = (i % 3 == 0); wr_data_i = 8'hFF;
        end
        wr_en_i = 1'b0;
        check("R9 held with writes", {7'd0, rd_data_o[4]}, 8'h01);
        @(negedge clk);
        check("R9 second flip", {7'd0, rd_data_o[4]}, 8'h00);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= LIMIT) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_writes();
        t_hold();
        t_t2();
        t_unused();
        t_refresh();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule